// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a row of storage stages that can be filled all at once from a parallel word and then emptied one bit at a time toward a single serial output. A serial input feeds the first stage, so several units can be cascaded by wiring the serial output of one unit into the serial input of the next. Only the last stage is visible, both as a true output and as its complement.

All logic runs on one fast system clock. The shift clock is not a clock net. It is formed as the OR of two external clock-like inputs, and the block detects each 0-to-1 transition of that OR. Either input can therefore act as a shift clock while the other is held low, or as an inhibit when it is held high. The active-low load input is a level override: while it is low, the stages follow the parallel inputs and ignore any shift activity. The load, serial and clock inputs pass through a synchronizer chain before use.

Top module: `plso_shreg`

## Requirements
- R1: An active-high synchronous reset clears every stage and the edge history to zero, so that after reset the true output is 0 and the inverted output is 1.
- R2: While the load input is low, the stages copy the parallel inputs (bit 0 into the first stage, bit WIDTH-1 into the last stage), and rising edges on either clock input cause no shift.
- R3: Loading is level-sensitive: if the parallel inputs change while load stays low, the stored word follows the new value, and that new value is what is shifted out after load is released.
- R4: With load high, each rising edge of the combined clock moves every stage one place toward the last stage. The serial input enters the first stage, the old last-stage bit is lost, and the true output shows the last stage.
- R5: The combined clock is the OR of the two clock inputs. A pulse on either input while the other is low causes exactly one shift, and the two inputs behave the same way.
- R6: While either clock input is held high, pulses on the other input cause no shift and the contents stay unchanged.
- R7: If one input rises while the other input is low, that counts as a rising edge of the combined clock and causes one shift, even when the rising input is being used as an inhibit.
- R8: A falling or steady combined clock causes no shift, and a single rising edge causes exactly one shift.
- R9: The edge history keeps tracking the combined clock during load, so releasing load while the combined clock is already high does not cause a shift.
- R10: The inverted output is always the complement of the true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n_i | input | 1 | Parallel load, active low, level sensitive |
| par_i | input | WIDTH | Parallel word; bit 0 goes to the first stage |
| ser_i | input | 1 | Serial input into the first stage |
| sclk_a_i | input | 1 | First clock input of the combined clock |
| sclk_b_i | input | 1 | Second clock input of the combined clock |
| q_last_o | output | 1 | Last stage, true |
| q_last_n_o | output | 1 | Last stage, inverted |

## Verification
Load and shift can arrive in the same system cycle, and load must win. The bench provokes this by pulsing each clock input while load is held low, and then by releasing load while a clock input is still high. It judges both cases by shifting the stored word out afterwards and comparing every bit with a software model. If any shift had slipped in, or a false edge had appeared at release, the whole sequence seen on the output would be offset by one place.

// File: rtl/plso_pkg.sv
package plso_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_SHIFT = 2'd2
   } plso_act_e;

   localparam int unsigned PLSO_MIN_WIDTH  = 2;
   localparam int unsigned PLSO_MIN_STAGES = 2;

endpackage

// File: rtl/plso_sync.sv
module plso_sync #(
   parameter int unsigned        WIDTH   = 1,
   parameter int unsigned        STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= RST_VAL;
      else     chain[0] <= d_i;
   end

   genvar s;
   generate
      for (s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_o = chain[LAST];
endmodule

// File: rtl/plso_edge.sv
module plso_edge (
   input  logic clk,
   input  logic rst,
   input  logic clk_a_s,
   input  logic clk_b_s,
   output logic rise_o
);
   logic eff;
   logic hist;

   assign eff = clk_a_s | clk_b_s;

   // History follows the combined clock in every cycle, load or not.
   always_ff @(posedge clk) begin
      if (rst) hist <= 1'b0;
      else     hist <= eff;
   end

   assign rise_o = eff & ~hist;
endmodule

// File: rtl/plso_core.sv
module plso_core
   import plso_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  plso_act_e        act_i,
   input  logic [WIDTH-1:0] par_i,
   input  logic             ser_i,
   output logic [WIDTH-1:0] stages_o
);
   logic [WIDTH-1:0] nxt;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         logic from_prev;
         if (i == 0) begin : g_head
            assign from_prev = ser_i;
         end else begin : g_body
            assign from_prev = stages_o[i-1];
         end

         always_comb begin
            unique case (act_i)
               ACT_LOAD:  nxt[i] = par_i[i];
               ACT_SHIFT: nxt[i] = from_prev;
               default:   nxt[i] = stages_o[i];
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) stages_o <= '0;
      else     stages_o <= nxt;
   end
endmodule

// File: rtl/plso_shreg.sv
module plso_shreg
   import plso_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_n_i,
   input  logic [WIDTH-1:0] par_i,
   input  logic             ser_i,
   input  logic             sclk_a_i,
   input  logic             sclk_b_i,
   output logic             q_last_o,
   output logic             q_last_n_o
);
   localparam int unsigned  MSB     = WIDTH - 1;
   localparam int unsigned  NSYNC   = 4;
   // Order {load_n, ser, a, b}; load_n resets high so reset does not load.
   localparam logic [NSYNC-1:0] SYNC_RST = 4'b1000;

   generate
      if (WIDTH < PLSO_MIN_WIDTH) begin : g_bad_width
         $error("plso_shreg: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < PLSO_MIN_STAGES) begin : g_bad_sync
         $error("plso_shreg: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             load_n_s;
   logic             ser_s;
   logic             clk_a_s;
   logic             clk_b_s;
   logic             shift_ev;
   plso_act_e        act;
   logic [WIDTH-1:0] stages;

   plso_sync #(
      .WIDTH   (NSYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i ({load_n_i, ser_i, sclk_a_i, sclk_b_i}),
      .q_o ({load_n_s, ser_s, clk_a_s, clk_b_s})
   );

   plso_edge u_edge (
      .clk     (clk),
      .rst     (rst),
      .clk_a_s (clk_a_s),
      .clk_b_s (clk_b_s),
      .rise_o  (shift_ev)
   );

   always_comb begin
      if (!load_n_s)     act = ACT_LOAD;
      else if (shift_ev) act = ACT_SHIFT;
      else               act = ACT_HOLD;
   end

   plso_core #(
      .WIDTH (WIDTH)
   ) u_core (
      .clk      (clk),
      .rst      (rst),
      .act_i    (act),
      .par_i    (par_i),
      .ser_i    (ser_s),
      .stages_o (stages)
   );

   assign q_last_o   = stages[MSB];
   assign q_last_n_o = ~stages[MSB];
endmodule

// File: rtl/plso_shreg_chk.sv
module plso_shreg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             load_n_s,
   input logic             ser_s,
   input logic             clk_a_s,
   input logic             clk_b_s,
   input logic             shift_ev,
   input logic [WIDTH-1:0] par_i,
   input logic [WIDTH-1:0] stages,
   input logic             q_last_o,
   input logic             q_last_n_o
);
   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (stages == '0));

   assert_load_follows_R2: assert property (@(posedge clk) disable iff (rst)
      !load_n_s |=> (stages == $past(par_i)));

   assert_shift_order_R4: assert property (@(posedge clk) disable iff (rst)
      (load_n_s && shift_ev) |=>
         (stages == {$past(stages[WIDTH-2:0]), $past(ser_s)}));

   assert_hold_steady_R8: assert property (@(posedge clk) disable iff (rst)
      (load_n_s && !shift_ev) |=> $stable(stages));

   assert_single_shift_R8: assert property (@(posedge clk) disable iff (rst)
      shift_ev |=> !shift_ev);

   assert_inhibit_a_R6: assert property (@(posedge clk) disable iff (rst)
      (clk_a_s && $past(clk_a_s)) |-> !shift_ev);

   assert_inhibit_b_R6: assert property (@(posedge clk) disable iff (rst)
      (clk_b_s && $past(clk_b_s)) |-> !shift_ev);

   assert_complement_R10: assert property (@(posedge clk) disable iff (rst)
      q_last_o != q_last_n_o);
endmodule

bind plso_shreg plso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .load_n_s   (load_n_s),
   .ser_s      (ser_s),
   .clk_a_s    (clk_a_s),
   .clk_b_s    (clk_b_s),
   .shift_ev   (shift_ev),
   .par_i      (par_i),
   .stages     (stages),
   .q_last_o   (q_last_o),
   .q_last_n_o (q_last_n_o)
);

// File: tb/plso_shreg_tb.sv
module plso_shreg_tb;
   localparam int W = 8;
   localparam int NVEC = 14;
   localparam int WATCHDOG = 100000;
   // Vector: {op[2:0], par[7:0], ser}
   localparam logic [2:0] OP_LOAD = 3'd0, OP_SHA = 3'd1, OP_SHB = 3'd2,
                          OP_INHA = 3'd3, OP_INHB = 3'd4, OP_RISE = 3'd5;
   localparam logic [11:0] VEC [NVEC] = '{
      {OP_LOAD, 8'hA5, 1'b0}, {OP_SHA,  8'h00, 1'b1}, {OP_SHA,  8'h00, 1'b0},
      {OP_SHB,  8'h00, 1'b1}, {OP_INHA, 8'h00, 1'b0}, {OP_SHB,  8'h00, 1'b0},
      {OP_INHB, 8'h00, 1'b1}, {OP_RISE, 8'h00, 1'b1}, {OP_SHA,  8'h00, 1'b1},
      {OP_LOAD, 8'h3C, 1'b0}, {OP_RISE, 8'h00, 1'b0}, {OP_SHB,  8'h00, 1'b1},
      {OP_INHA, 8'h00, 1'b1}, {OP_SHA,  8'h00, 1'b0}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load_n = 1'b1;
   logic ser = 1'b0;
   logic ca = 1'b0;
   logic cb = 1'b0;
   logic [W-1:0] par = '0;
   logic q, qn;
   logic [W-1:0] model = '0;
   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   plso_shreg #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
      .clk (clk), .rst (rst), .load_n_i (load_n), .par_i (par),
      .ser_i (ser), .sclk_a_i (ca), .sclk_b_i (cb),
      .q_last_o (q), .q_last_n_o (qn)
   );

   task automatic settle();
      repeat (5) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp);
      n_chk++;
      if (q !== exp) begin
         n_fail++;
         $display("FAIL %s: q=%b expected %b", req, q, exp);
      end
      n_chk++;
      if (qn !== ~exp) begin
         n_fail++;
         $display("FAIL R10: qn=%b expected %b", qn, ~exp);
      end
   endtask

   task automatic mshift(input logic s);
      model = {model[W-2:0], s};
   endtask

   task automatic pulse_a();
      ca = 1'b1; settle(); ca = 1'b0; settle();
   endtask

   task automatic pulse_b();
      cb = 1'b1; settle(); cb = 1'b0; settle();
   endtask

   task automatic run_vec(input logic [11:0] v);
      logic [2:0] op;
      logic [W-1:0] p;
      logic s;
      op = v[11:9]; p = v[8:1]; s = v[0];
      ser = s; settle();
      case (op)
         OP_LOAD: begin
            load_n = 1'b0; par = p; settle();
            load_n = 1'b1; settle();
            model = p; check("R2 load", model[W-1]);
         end
         OP_SHA: begin
            pulse_a(); mshift(s); check("R5 shift via a", model[W-1]);
         end
         OP_SHB: begin
            pulse_b(); mshift(s); check("R5 shift via b", model[W-1]);
         end
         OP_INHA: begin
            ca = 1'b1; settle(); mshift(s); check("R7 inhibit a rising", model[W-1]);
            pulse_b(); check("R6 inhibit by a", model[W-1]);
            ca = 1'b0; settle(); check("R8 falling a", model[W-1]);
         end
         OP_INHB: begin
            cb = 1'b1; settle(); mshift(s); check("R7 inhibit b rising", model[W-1]);
            pulse_a(); check("R6 inhibit by b", model[W-1]);
            cb = 1'b0; settle(); check("R8 falling b", model[W-1]);
         end
         default: begin
            cb = 1'b1; settle(); mshift(s); check("R7 rise while other low", model[W-1]);
            cb = 1'b0; settle(); check("R8 no shift on fall", model[W-1]);
         end
      endcase
   endtask

   initial begin
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      n_fail++;
      $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1 reset state", 1'b0);
      rst = 1'b0;
      settle();
      check("R1 after reset release", 1'b0);

      for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

      // R2: clock pulses during load must not shift
      load_n = 1'b0; par = 8'h80; settle();
      pulse_a(); pulse_b();
      check("R2 clock during load", 1'b1);
      load_n = 1'b1; settle();
      model = 8'h80; ser = 1'b0; settle();
      for (int k = 0; k < W - 1; k++) begin
         pulse_a(); mshift(1'b0); check("R2 contents after load", model[W-1]);
      end

      // R3: parallel inputs change while load is held low
      load_n = 1'b0; par = 8'h5A; settle();
      check("R3 track first word", 1'b0);
      par = 8'hC3; settle();
      check("R3 track second word", 1'b1);
      load_n = 1'b1; settle();
      model = 8'hC3; ser = 1'b1; settle();
      for (int k = 0; k < W; k++) begin
         pulse_b(); mshift(1'b1); check("R3 shifted word bit", model[W-1]);
      end

      // R9: release load with combined clock already high
      load_n = 1'b0; par = 8'h81; ca = 1'b1; settle();
      load_n = 1'b1; settle();
      model = 8'h81;
      check("R9 no shift at release", model[W-1]);
      ca = 1'b0; settle();
      check("R9 no shift on fall", model[W-1]);
      ser = 1'b0; settle();
      pulse_b(); mshift(1'b0);
      check("R4 shift after release", model[W-1]);

      // R1: reset in mid-run
      load_n = 1'b0; par = 8'hFF; settle(); load_n = 1'b1; settle();
      check("R1 preload ones", 1'b1);
      rst = 1'b1; settle();
      check("R1 mid-run reset", 1'b0);
      rst = 1'b0; settle();
      model = '0;
      pulse_a(); mshift(1'b0);
      check("R1 cleared contents", model[W-1]);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule